// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a bank of general-purpose I/O lines controlled through a simple single-cycle register port. Software reaches five registers through a 3-bit address: a level register, a drive-set register, a drive-clear register, an output-enable register and an input-enable register. All of them act on two pieces of state, the output latch and the direction vector. The block drives one output value and one output enable per line, and samples one input per line through a two-flop synchroniser. There is one line for each register bit.

Parameters fix the register width (8, 16, 32 or 64 lines). A mirrored line order can be selected, in which line n sits at register bit WIDTH-1-n. A byte-reversed bus order can also be selected, which is legal only at widths 16 and 32. The drive-set/drive-clear pair and the output-enable/input-enable pair are two views of the same state. Writing either member of a pair updates the other at once, so no line can be both an input and an output.

Each write and read is decoded into an access kind (IDLE, WRITE, READ, WRITE_READ) and then into a register operation (NONE, LOAD, SET, CLEAR, DIR_OUT, DIR_IN). A write updates state at the clock edge that samples it. A read returns its data one cycle later.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: During and after reset, pin_out, pin_oe and reg_rdata are all zero, so every line comes up as an input.
- R2: A write to address 0 (level) loads the output latch with the written lines. A read of address 0 returns, for each line, the latch bit if the line is an output and the synchronised pin if it is an input.
- R3: A write to address 1 (drive-set) sets every latch bit written as 1 and leaves the bits written as 0 unchanged.
- R4: A write to address 2 (drive-clear) clears every latch bit written as 1 and leaves the others unchanged. A read of address 2 returns zero.
- R5: A write to address 3 (output-enable) loads the direction vector (1 = output), which appears on pin_oe. A read of address 3 returns it.
- R6: A write to address 4 (input-enable) loads the direction vector with the inverse of the written value. A read of address 4 always returns the bitwise inverse of the output-enable register.
- R7: With MIRROR = 1, line n maps to register bit WIDTH-1-n in every register, for both reads and writes.
- R8: With BYTE_SWAP = 1, byte k of the bus corresponds to register byte NB-1-k, where NB = WIDTH/8. Only widths 16 and 32 accept it. Any width other than 8, 16, 32 or 64 is rejected at elaboration, and so is WIDTH 64 with BYTE_SWAP.
- R9: A change on pin_in is visible to a level read sampled no sooner than the third clock edge after the change. Reads sampled at the first two edges return the old level.
- R10: reg_rdata updates one cycle after reg_rd and otherwise holds its value. A read in the same cycle as a write returns the value from before that write.
- R11: Writes to addresses 5 to 7 change nothing, and reads of those addresses return zero.
- R12: A read of address 1 returns the output latch, whatever the direction of each line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | WIDTH | Write data (bus order) |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | WIDTH | Read data, valid the cycle after reg_rd |
| pin_in | input | WIDTH | Raw line inputs |
| pin_out | output | WIDTH | Output latch, one bit per line |
| pin_oe | output | WIDTH | Output enable, one bit per line |

## Verification
A corrupted latch or direction bit appears on pin_out or pin_oe one cycle after the write that caused it. It also appears in the next drive-set or output-enable read. A wrong lane permutation shows only in a mirrored or byte-swapped configuration, so a second instance at width 16 with both options runs next to the plain 32-bit one. A wrong synchroniser depth shows as a level read that changes one edge too early or too late after a pin edge.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LEVEL = 3'd0,
        SEL_SET   = 3'd1,
        SEL_CLR   = 3'd2,
        SEL_OUTEN = 3'd3,
        SEL_INEN  = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_WRITE,
        ACC_READ,
        ACC_WRITE_READ
    } acc_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD,
        OP_SET,
        OP_CLEAR,
        OP_DIR_OUT,
        OP_DIR_IN
    } bank_op_e;

endpackage

// File: rtl/gpio_lane_map.sv
// Bus-order <-> line-order permutation. Both stages are reflections that
// commute, so the same instance type serves the write and the read path.
module gpio_lane_map #(
    parameter int WIDTH     = 32,
    parameter bit MIRROR    = 1'b0,
    parameter bit BYTE_SWAP = 1'b0
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [WIDTH-1:0] vec_o
);
    localparam int NB = WIDTH / 8;

    logic [WIDTH-1:0] swapped;

    for (genvar i = 0; i < WIDTH; i++) begin : g_swap
        if (BYTE_SWAP) begin : g_on
            assign swapped[i] = vec_i[(NB - 1 - i / 8) * 8 + (i % 8)];
        end else begin : g_off
            assign swapped[i] = vec_i[i];
        end
    end

    for (genvar j = 0; j < WIDTH; j++) begin : g_mirror
        if (MIRROR) begin : g_on
            assign vec_o[j] = swapped[WIDTH - 1 - j];
        end else begin : g_off
            assign vec_o[j] = swapped[j];
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= raw_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/gpio_bank_regs.sv
// Output latch and direction vector, both in line order.
module gpio_bank_regs
    import gpio_mmio_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bank_op_e         op_i,
    input  logic [WIDTH-1:0] lines_i,
    output logic [WIDTH-1:0] latch_o,
    output logic [WIDTH-1:0] dir_o
);
    logic [WIDTH-1:0] latch_q, latch_d;
    logic [WIDTH-1:0] dir_q, dir_d;

    always_comb begin
        latch_d = latch_q;
        dir_d   = dir_q;
        unique case (op_i)
            OP_NONE:    ;
            OP_LOAD:    latch_d = lines_i;
            OP_SET:     latch_d = latch_q | lines_i;
            OP_CLEAR:   latch_d = latch_q & ~lines_i;
            OP_DIR_OUT: dir_d   = lines_i;
            OP_DIR_IN:  dir_d   = ~lines_i;
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else begin
            latch_q <= latch_d;
            dir_q   <= dir_d;
        end
    end

    assign latch_o = latch_q;
    assign dir_o   = dir_q;
endmodule

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl
    import gpio_mmio_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter bit MIRROR    = 1'b0,
    parameter bit BYTE_SWAP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [WIDTH-1:0]  reg_wdata,
    input  logic              reg_rd,
    output logic [WIDTH-1:0]  reg_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe
);
    localparam bit WIDTH_OK = (WIDTH == 8) || (WIDTH == 16) ||
                              (WIDTH == 32) || (WIDTH == 64);
    localparam bit SWAP_OK  = !BYTE_SWAP || (WIDTH == 16) || (WIDTH == 32);

    if (!(WIDTH_OK && SWAP_OK)) begin : g_cfg_reject
        $error("gpio_mmio_ctrl: unsupported WIDTH/BYTE_SWAP combination");
    end

    logic [WIDTH-1:0] wr_lines;
    logic [WIDTH-1:0] rd_lines;
    logic [WIDTH-1:0] rd_bus;
    logic [WIDTH-1:0] latch;
    logic [WIDTH-1:0] dir;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] rdata_q;
    acc_e             acc;
    bank_op_e         op;

    gpio_lane_map #(.WIDTH(WIDTH), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) u_wr_map (
        .vec_i (reg_wdata),
        .vec_o (wr_lines)
    );

    gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_in),
        .sync_o (pin_sync)
    );

    gpio_bank_regs #(.WIDTH(WIDTH)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op),
        .lines_i (wr_lines),
        .latch_o (latch),
        .dir_o   (dir)
    );

    // Access kind of the current cycle.
    always_comb begin
        unique case ({reg_wr, reg_rd})
            2'b00:   acc = ACC_IDLE;
            2'b10:   acc = ACC_WRITE;
            2'b01:   acc = ACC_READ;
            default: acc = ACC_WRITE_READ;
        endcase
    end

    // Write decode into a bank operation.
    always_comb begin
        op = OP_NONE;
        if (acc == ACC_WRITE || acc == ACC_WRITE_READ) begin
            unique case (reg_addr)
                SEL_LEVEL: op = OP_LOAD;
                SEL_SET:   op = OP_SET;
                SEL_CLR:   op = OP_CLEAR;
                SEL_OUTEN: op = OP_DIR_OUT;
                SEL_INEN:  op = OP_DIR_IN;
                default:   op = OP_NONE;
            endcase
        end
    end

    // Read source, in line order, taken from pre-write state.
    always_comb begin
        unique case (reg_addr)
            SEL_LEVEL: rd_lines = (dir & latch) | (~dir & pin_sync);
            SEL_SET:   rd_lines = latch;
            SEL_CLR:   rd_lines = '0;
            SEL_OUTEN: rd_lines = dir;
            SEL_INEN:  rd_lines = ~dir;
            default:   rd_lines = '0;
        endcase
    end

    gpio_lane_map #(.WIDTH(WIDTH), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) u_rd_map (
        .vec_i (rd_lines),
        .vec_o (rd_bus)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (acc == ACC_READ || acc == ACC_WRITE_READ) begin
            rdata_q <= rd_bus;
        end
    end

    assign reg_rdata = rdata_q;
    assign pin_out   = latch;
    assign pin_oe    = dir;
endmodule

// File: rtl/gpio_mmio_chk.sv
module gpio_mmio_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       reg_addr,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [WIDTH-1:0] reg_rdata,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] pin_oe,
    input logic [WIDTH-1:0] wr_lines
);
    p_set_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1) |=> ((pin_out & $past(wr_lines)) == $past(wr_lines)));

    p_set_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1) |=>
            ((pin_out & ~$past(wr_lines)) == ($past(pin_out) & ~$past(wr_lines))));

    p_clr_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd2) |=> ((pin_out & $past(wr_lines)) == '0));

    p_outen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd3) |=> (pin_oe == $past(wr_lines)));

    p_inen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd4) |=> (pin_oe == ~$past(wr_lines)));

    p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr || reg_addr > 3'd4) |=> ($stable(pin_out) && $stable(pin_oe)));

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

bind gpio_mmio_ctrl gpio_mmio_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .wr_lines  (wr_lines)
);

// File: tb/tb_gpio_mmio_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_mmio_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // Plain 32-bit instance
    logic [2:0]  a_addr = '0;
    logic        a_wr = 1'b0, a_rd = 1'b0;
    logic [31:0] a_wdata = '0, a_rdata, a_pin = 32'hA5A5_0F0F, a_out, a_oe;
    // 16-bit instance, mirrored and byte-swapped
    logic [2:0]  x_addr = '0;
    logic        x_wr = 1'b0, x_rd = 1'b0;
    logic [15:0] x_wdata = '0, x_rdata, x_pin = 16'h0001, x_out, x_oe;

    int checks = 0;
    int errors = 0;

    gpio_mmio_ctrl #(.WIDTH(32)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(a_addr), .reg_wr(a_wr), .reg_wdata(a_wdata),
        .reg_rd(a_rd), .reg_rdata(a_rdata), .pin_in(a_pin), .pin_out(a_out), .pin_oe(a_oe)
    );

    gpio_mmio_ctrl #(.WIDTH(16), .MIRROR(1'b1), .BYTE_SWAP(1'b1)) dut_x (
        .clk(clk), .rst_n(rst_n), .reg_addr(x_addr), .reg_wr(x_wr), .reg_wdata(x_wdata),
        .reg_rd(x_rd), .reg_rdata(x_rdata), .pin_in(x_pin), .pin_out(x_out), .pin_oe(x_oe)
    );

    typedef struct packed {
        logic [31:0] tag;
        logic [2:0]  wa;
        logic [31:0] wd;
        logic [2:0]  ra;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{"R6",  3'd3, 32'hFFFF_0000, 3'd4, 32'h0000_FFFF},
        '{"R2",  3'd0, 32'h1234_5678, 3'd1, 32'h1234_5678},
        '{"R3",  3'd1, 32'h0000_00F0, 3'd1, 32'h1234_56F8},
        '{"R4",  3'd2, 32'h1200_0008, 3'd1, 32'h0034_56F0},
        '{"R5",  3'd4, 32'h0000_FFFF, 3'd3, 32'hFFFF_0000},
        '{"R2",  3'd5, 32'hFFFF_FFFF, 3'd0, 32'h0034_0F0F},
        '{"R4",  3'd2, 32'h0000_0000, 3'd2, 32'h0000_0000},
        '{"R12", 3'd1, 32'h0000_0000, 3'd1, 32'h0034_56F0},
        '{"R11", 3'd6, 32'h0000_DEAD, 3'd7, 32'h0000_0000},
        '{"R11", 3'd7, 32'hFFFF_FFFF, 3'd3, 32'hFFFF_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic a_write(input logic [2:0] ad, input logic [31:0] d);
        @(negedge clk);
        a_addr = ad; a_wdata = d; a_wr = 1'b1;
        @(negedge clk);
        a_wr = 1'b0;
    endtask

    task automatic a_read(input logic [2:0] ad, output logic [31:0] d);
        @(negedge clk);
        a_addr = ad; a_rd = 1'b1;
        @(negedge clk);
        a_rd = 1'b0;
        d = a_rdata;
    endtask

    task automatic x_write(input logic [2:0] ad, input logic [15:0] d);
        @(negedge clk);
        x_addr = ad; x_wdata = d; x_wr = 1'b1;
        @(negedge clk);
        x_wr = 1'b0;
    endtask

    task automatic x_read(input logic [2:0] ad, output logic [15:0] d);
        @(negedge clk);
        x_addr = ad; x_rd = 1'b1;
        @(negedge clk);
        x_rd = 1'b0;
        d = x_rdata;
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic [15:0] rx;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", a_out, 32'h0);
        check("R1", a_oe, 32'h0);
        check("R1", a_rdata, 32'h0);
        check("R1", {16'h0, x_oe}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", a_out, 32'h0);

        // Table walk: write one register, then read one back
        for (int i = 0; i < NV; i++) begin
            a_write(VECS[i].wa, VECS[i].wd);
            a_read(VECS[i].ra, r);
            check(string'(VECS[i].tag), r, VECS[i].exp);
        end
        check("R5", a_oe, 32'hFFFF_0000);
        check("R2", a_out, 32'h0034_56F0);

        // R9: input change reaches level reads on the third edge
        @(negedge clk);
        a_pin = 32'hA5A5_1234;
        a_addr = 3'd0; a_rd = 1'b1;
        @(negedge clk);
        check("R9", a_rdata, 32'h0034_0F0F);
        @(negedge clk);
        check("R9", a_rdata, 32'h0034_0F0F);
        @(negedge clk);
        a_rd = 1'b0;
        check("R9", a_rdata, 32'h0034_1234);
        @(negedge clk);
        check("R10", a_rdata, 32'h0034_1234);

        // R10: read in the same cycle as a write returns the old value
        @(negedge clk);
        a_addr = 3'd1; a_wdata = 32'hFF00_0000; a_wr = 1'b1; a_rd = 1'b1;
        @(negedge clk);
        a_wr = 1'b0; a_rd = 1'b0;
        check("R10", a_rdata, 32'h0034_56F0);
        a_read(3'd1, r);
        check("R10", r, 32'hFF34_56F0);
        check("R3", a_out, 32'hFF34_56F0);

        // R7 and R8 on the mirrored, byte-swapped instance
        x_write(3'd3, 16'h0001);
        check("R7", {16'h0, x_oe}, 32'h0000_0080);
        x_write(3'd1, 16'h8000);
        check("R8", {16'h0, x_out}, 32'h0000_0100);
        repeat (3) @(negedge clk);
        x_read(3'd0, rx);
        check("R7", {16'h0, rx}, 32'h0000_0080);
        x_read(3'd1, rx);
        check("R8", {16'h0, rx}, 32'h0000_8000);
        x_read(3'd4, rx);
        check("R6", {16'h0, rx}, 32'h0000_FFFE);
        x_write(3'd0, 16'h00FF);
        check("R8", {16'h0, x_out}, 32'h0000_00FF);

        finish_run();
    end
endmodule